// File: doc/BRIEF.md
# Saturating Wiper Position Controller with Stored Setting

This block is the digital control core of a 100-step digitally adjustable potentiometer. A host drives three slow, asynchronous control lines: an active-low select, a step strobe and a direction level. The block keeps the wiper position in a counter whose legal values are 0 through 99. It drives a one-hot select across the 100 taps and keeps a retained copy of the position that models a nonvolatile cell.

A host selects the block by pulling select low. Each high-to-low edge on the step strobe moves the wiper one position. The direction is set by the level of the direction line at that edge. The wiper stops at the ends and never wraps. How the host releases select decides what happens next. If the strobe is high, the current position is written to the retained copy, and the block reports busy for a programmable number of clock cycles. If the strobe is low, the block returns to idle with no write. A power-good input models the supply. While it is low the block is off. When it rises, the wiper is reloaded from the retained copy.

Top module: `wpot_ctrl`

## Requirements
- R1: After reset with power-good held high, the position is 0, tap bit 0 alone is set, busy is low and standby is high.
- R2: While selected, a falling edge of the step strobe moves the position by one: up when the direction level is 1, down when it is 0.
- R3: The position never leaves 0..99. A step up at 99 and a step down at 0 leave it unchanged.
- R4: The tap output always has exactly one bit set, at the index equal to the position.
- R5: Releasing select while the step strobe is high writes the position to the retained copy. Busy is then high for exactly STORE_CYC clock cycles, with standby low. Standby is high once busy drops.
- R6: Releasing select while the step strobe is low writes nothing, raises no busy and keeps the current position.
- R7: While power-good is low, the position reads 0, standby is low and all control activity is ignored. When power-good rises, the position is reloaded from the retained copy, clamped to 99.
- R8: While busy, step edges and select falls are ignored. A select fall that arrives during busy does not select the block once busy ends.
- R9: Changing the direction level without a step edge never moves the position.
- R10: When select rises in the same sampled cycle as a step-strobe fall, the block neither steps nor writes, and it returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also sets the retained copy to NV_INIT |
| pwr_good_i | input | 1 | Supply present (asynchronous); rising edge triggers recall |
| cs_n_i | input | 1 | Active-low select (asynchronous) |
| inc_i | input | 1 | Step strobe, acts on its falling edge (asynchronous) |
| ud_i | input | 1 | Direction level, 1 = up (asynchronous) |
| pos_o | output | 7 | Current wiper position 0..99 |
| tap_o | output | 100 | One-hot tap select |
| busy_o | output | 1 | Retained-copy write in progress |
| standby_o | output | 1 | Powered, not selected and not busy |

## Verification
A falling step strobe and a rising select can land in the same synchronized cycle. One means a move and the other a release, and either one alone would change state. The bench provokes this by driving both lines in the same half-period, so both pass through matching synchronizer stages together. It then judges by the position, by whether busy ever rises, and by standby. It also walks select falls and strobe edges through a busy window and checks that they leave no trace after the window closes.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
    localparam int TAPS  = 100;
    localparam int POS_W = $clog2(TAPS);

    typedef logic [POS_W-1:0] pos_t;
    localparam pos_t POS_MAX = pos_t'(TAPS - 1);

    // synchronized control levels
    typedef struct packed {
        logic pwr;
        logic sel_n;
        logic inc;
        logic up;
    } ctl_t;

    // single-cycle events derived from the synchronized levels
    typedef struct packed {
        logic pwr_rise;
        logic sel_fall;
        logic sel_rise;
        logic inc_fall;
    } evt_t;

    function automatic pos_t clamp_pos(pos_t v);
        return (v > POS_MAX) ? POS_MAX : v;
    endfunction

    function automatic pos_t step_pos(pos_t v, logic up);
        if (up)
            return (v >= POS_MAX) ? POS_MAX : pos_t'(v + 1'b1);
        return (v == '0) ? '0 : pos_t'(v - 1'b1);
    endfunction
endpackage

// File: rtl/wpot_sync.sv
module wpot_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d_i;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wpot_nvctl.sv
module wpot_nvctl
    import wpot_pkg::*;
#(
    parameter int   STORE_CYC = 2_500_000,
    parameter pos_t NV_INIT   = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic powered_i,
    input  evt_t evt_i,
    input  logic inc_lvl_i,
    input  pos_t pos_i,
    output logic sel_o,
    output logic busy_o,
    output pos_t nv_o
);
    localparam int CNT_W = (STORE_CYC > 1) ? $clog2(STORE_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_o  <= 1'b0;
            busy_o <= 1'b0;
            cnt_q  <= '0;
            nv_o   <= NV_INIT;
        end else if (!powered_i) begin
            sel_o  <= 1'b0;
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_o) begin
            if (cnt_q == '0)
                busy_o <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end else if (evt_i.sel_fall) begin
            sel_o <= 1'b1;
        end else if (sel_o && evt_i.sel_rise) begin
            sel_o <= 1'b0;
            if (inc_lvl_i) begin
                nv_o   <= pos_i;
                busy_o <= 1'b1;
                cnt_q  <= CNT_LAST;
            end
        end
    end
endmodule

// File: rtl/wpot_pos.sv
module wpot_pos
    import wpot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic powered_i,
    input  logic recall_i,
    input  pos_t nv_i,
    input  logic step_i,
    input  logic up_i,
    output pos_t pos_o
);
    always_ff @(posedge clk) begin
        if (rst || !powered_i)
            pos_o <= '0;
        else if (recall_i)
            pos_o <= clamp_pos(nv_i);
        else if (step_i)
            pos_o <= step_pos(pos_o, up_i);
    end
endmodule

// File: rtl/wpot_tapdec.sv
module wpot_tapdec
    import wpot_pkg::*;
(
    input  pos_t            pos_i,
    output logic [TAPS-1:0] tap_o
);
    generate
        for (genvar i = 0; i < TAPS; i++) begin : g_tap
            assign tap_o[i] = (pos_i == pos_t'(i));
        end
    endgenerate
endmodule

// File: rtl/wpot_ctrl.sv
module wpot_ctrl
    import wpot_pkg::*;
#(
    parameter int   STORE_CYC   = 2_500_000,
    parameter int   SYNC_STAGES = 2,
    parameter pos_t NV_INIT     = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pwr_good_i,
    input  logic                    cs_n_i,
    input  logic                    inc_i,
    input  logic                    ud_i,
    output logic [POS_W-1:0]        pos_o,
    output logic [TAPS-1:0]         tap_o,
    output logic                    busy_o,
    output logic                    standby_o
);
    localparam int CTL_W = $bits(ctl_t);

    logic [CTL_W-1:0] sync_q;
    ctl_t             now;
    logic [2:0]       prev_q;   // pwr, sel_n, inc of the previous cycle
    evt_t             evt;
    logic             sel, busy, step;
    pos_t             pos, nv;

    wpot_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({pwr_good_i, cs_n_i, inc_i, ud_i}),
        .q_o (sync_q)
    );

    assign now = ctl_t'(sync_q);

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= {now.pwr, now.sel_n, now.inc};
    end

    always_comb begin
        evt.pwr_rise = now.pwr   & ~prev_q[2];
        evt.sel_rise = now.sel_n & ~prev_q[1];
        evt.sel_fall = ~now.sel_n & prev_q[1];
        evt.inc_fall = ~now.inc  & prev_q[0];
    end

    assign step = now.pwr & sel & ~busy & ~now.sel_n & evt.inc_fall;

    wpot_nvctl #(.STORE_CYC(STORE_CYC), .NV_INIT(NV_INIT)) u_nv (
        .clk       (clk),
        .rst       (rst),
        .powered_i (now.pwr),
        .evt_i     (evt),
        .inc_lvl_i (now.inc),
        .pos_i     (pos),
        .sel_o     (sel),
        .busy_o    (busy),
        .nv_o      (nv)
    );

    wpot_pos u_pos (
        .clk       (clk),
        .rst       (rst),
        .powered_i (now.pwr),
        .recall_i  (evt.pwr_rise),
        .nv_i      (nv),
        .step_i    (step),
        .up_i      (now.up),
        .pos_o     (pos)
    );

    wpot_tapdec u_dec (
        .pos_i (pos),
        .tap_o (tap_o)
    );

    assign pos_o     = pos;
    assign busy_o    = busy;
    assign standby_o = now.pwr & ~busy & ~sel;
endmodule

// File: rtl/wpot_ctrl_chk.sv
module wpot_ctrl_chk
    import wpot_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [POS_W-1:0] pos_o,
    input logic [TAPS-1:0] tap_o,
    input logic            busy_o,
    input logic            standby_o
);
    // R4
    tap_match_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(tap_o) == 1) && tap_o[pos_o]);

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_o <= POS_MAX);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(pos_o));

    // R5
    busy_standby_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !standby_o);
endmodule

bind wpot_ctrl wpot_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pos_o     (pos_o),
    .tap_o     (tap_o),
    .busy_o    (busy_o),
    .standby_o (standby_o)
);

// File: tb/tb_wpot_ctrl.sv
`timescale 1ns/1ps
module tb_wpot_ctrl;
    localparam int STORE_CYC = 40;
    localparam int NTAP = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b1;
    logic cs_n = 1'b1;
    logic inc = 1'b1;
    logic ud = 1'b1;
    logic [6:0] pos;
    logic [NTAP-1:0] tap;
    logic busy, standby;

    int total = 0;
    int bad = 0;
    int exp_pos = 0;
    int exp_nv = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wpot_ctrl #(.STORE_CYC(STORE_CYC)) dut (
        .clk(clk), .rst(rst), .pwr_good_i(pwr_good), .cs_n_i(cs_n),
        .inc_i(inc), .ud_i(ud), .pos_o(pos), .tap_o(tap),
        .busy_o(busy), .standby_o(standby)
    );

    function automatic int model_step(int p, bit up);
        if (up) return (p >= 99) ? 99 : p + 1;
        return (p <= 0) ? 0 : p - 1;
    endfunction

    function automatic logic [NTAP-1:0] model_tap(int p);
        logic [NTAP-1:0] t = '0;
        t[p] = 1'b1;
        return t;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pos(string req);
        chk(req, int'(pos), exp_pos);
        total++;
        if (tap !== model_tap(exp_pos)) begin
            bad++;
            $display("FAIL R4 (%s): tap actual=%h expected=%h", req, tap, model_tap(exp_pos));
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select_blk();
        @(negedge clk); inc = 1'b1; cs_n = 1'b0; wait_n(5);
    endtask

    task automatic step(bit up, bit leave_low);
        @(negedge clk); ud = up; wait_n(4);
        inc = 1'b0; wait_n(5);
        exp_pos = model_step(exp_pos, up);
        if (!leave_low) begin inc = 1'b1; wait_n(5); end
    endtask

    // count busy width after a release with store
    task automatic measure_busy(string req, int exp_w);
        int w = 0;
        int guard = 0;
        while (!busy && guard < 8) begin @(negedge clk); guard++; end
        while (busy && w < 10 * STORE_CYC) begin @(negedge clk); w++; end
        chk(req, w, exp_w);
    endtask

    task automatic release_store();
        @(negedge clk); inc = 1'b1; cs_n = 1'b1;
        exp_nv = exp_pos;
        measure_busy("R5 busy width", STORE_CYC);
        wait_n(1);
        chk("R5 standby after store", int'(standby), 1);
    endtask

    task automatic release_nostore(bit up);
        step(up, 1'b1);
        @(negedge clk); cs_n = 1'b1; wait_n(5);
        chk("R6 no busy", int'(busy), 0);
        chk("R6 standby", int'(standby), 1);
        @(negedge clk); inc = 1'b1; wait_n(4);
        chk_pos("R6 position kept");
    endtask

    task automatic power_cycle();
        @(negedge clk); pwr_good = 1'b0; wait_n(5);
        chk("R7 off position", int'(pos), 0);
        chk("R7 off standby", int'(standby), 0);
        cs_n = 1'b0; wait_n(3); inc = 1'b0; wait_n(3); inc = 1'b1; cs_n = 1'b1; wait_n(4);
        chk("R7 off ignores inputs", int'(pos), 0);
        pwr_good = 1'b1; wait_n(6);
        exp_pos = exp_nv;
        chk_pos("R7 recall");
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        wait_n(4);
        rst = 1'b0;
        wait_n(6);
        // R1
        chk_pos("R1 reset position");
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset standby", int'(standby), 1);

        // R2 directed
        select_blk();
        chk("R2 selected not standby", int'(standby), 0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        chk_pos("R2 up five");
        step(1'b0, 1'b0); step(1'b0, 1'b0);
        chk_pos("R2 down two");

        // R9: direction toggles alone
        for (int i = 0; i < 6; i++) begin @(negedge clk); ud = ~ud; wait_n(3); end
        chk_pos("R9 direction only");

        // R3 saturation at both ends
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        chk_pos("R3 floor at 0");
        for (int i = 0; i < 104; i++) step(1'b1, 1'b0);
        chk_pos("R3 ceiling at 99");

        // R5 store
        release_store();
        chk_pos("R5 position after store");

        // R8: select fall and steps during busy
        select_blk(); step(1'b0, 1'b0); step(1'b0, 1'b0);
        @(negedge clk); inc = 1'b1; cs_n = 1'b1;
        while (!busy) @(negedge clk);
        exp_nv = exp_pos;
        cs_n = 1'b0; wait_n(4);
        inc = 1'b0; wait_n(4); inc = 1'b1; wait_n(4);
        chk_pos("R8 step during busy ignored");
        while (busy) @(negedge clk);
        step(1'b1, 1'b0);
        exp_pos = exp_nv;   // step after busy must not act
        chk_pos("R8 late select ignored");
        @(negedge clk); cs_n = 1'b1; wait_n(6);
        chk("R8 no store from stale select", int'(busy), 0);

        // R7 recall of stored 97
        power_cycle();

        // R6
        select_blk();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        release_nostore(1'b0);
        power_cycle();   // recalls 97, not the unsaved value

        // R10: step fall and select rise in the same half-period
        select_blk();
        step(1'b0, 1'b0);
        @(negedge clk); inc = 1'b0; cs_n = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) seen = 1; end
            chk("R10 no store", seen, 0);
        end
        chk_pos("R10 no step");
        chk("R10 standby", int'(standby), 1);
        @(negedge clk); inc = 1'b1; wait_n(3);
        power_cycle();

        // random sessions
        for (int s = 0; s < 150; s++) begin
            int n = 1 + ($urandom % 8);
            select_blk();
            for (int k = 0; k < n; k++) step(1'($urandom % 2), 1'b0);
            chk_pos("R2 random steps");
            if ($urandom % 2) release_store();
            else release_nostore(1'($urandom % 2));
            if ($urandom % 10 == 0) power_cycle();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule